// File: doc/BRIEF.md
# Paged management-register access bridge

This block lets a host reach 32-bit switch registers that are only reachable through 16-bit clause-22 management transactions. The host issues one request at a time (read, write or masked modify) with a byte address. The bridge splits the word into a low half at the aligned address and a high half two bytes above it. For every half it first writes a page value to a fixed page-select location, then performs the half-word access at a PHY address and register number taken from the byte address.

The transactions leave on a command port toward an existing management master. That master acknowledges each one with a done pulse, read data and an error flag. The host sees `busy` while a sequence runs and receives a one-cycle response carrying the read word and an error flag. A debug output holds the most recent page value that was acknowledged.

Top module: `paged_reg_bridge`

## Requirements
- R1: For a half-word at byte address H, the access goes to PHY 0x10 + H[8:6] and register H[5:1], and the page value is H shifted right by 9, truncated to 16 bits.
- R2: Every half-word access is preceded by a write of the page value to PHY 0x18, register 0, even when the value equals the page written just before.
- R3: Op code 2'b01 (write) issues page write, low write of wdata[15:0] at A, page write, high write of wdata[31:16] at A+2, and responds with data 0.
- R4: Op code 2'b00 (read) issues page write, low read at A, page write, high read at A+2, and responds with {high, low}.
- R5: Op code 2'b10 (modify) performs the full read of R4 and then the full write of R3 with data (old & ~req_mask) | req_wdata, and responds with the old word.
- R6: Address bits [1:0] are ignored; the transactions are those of the address with both bits cleared.
- R7: `busy` rises in the cycle after a request is accepted, falls in the cycle `rsp_valid` is high, and `rsp_valid` lasts one cycle; a request presented while `busy` is high is not accepted.
- R8: `cmd_valid` and the command fields hold steady until `cmd_done`, and the next command of a sequence is presented in the cycle after that done.
- R9: A done with `cmd_err` high ends the sequence at once, with no later command, and the response carries `rsp_err`=1 and data 0.
- R10: `last_page` shows the value of the most recent page write that was acknowledged without error.
- R11: After reset `busy`, `cmd_valid` and `rsp_valid` are low and `last_page` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_op | input | 2 | 00 read, 01 write, 10 modify, 11 read |
| req_addr | input | ADDR_W | Byte address of the 32-bit register |
| req_wdata | input | WORD_W | Write data, or bits to set for modify |
| req_mask | input | WORD_W | Bits to clear for modify |
| busy | output | 1 | Sequence in progress |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Sequence aborted by a downstream error |
| rsp_rdata | output | WORD_W | Read word (old word for modify) |
| cmd_valid | output | 1 | Management command pending |
| cmd_write | output | 1 | 1 write, 0 read |
| cmd_phy | output | 5 | PHY address |
| cmd_reg | output | 5 | Register number |
| cmd_wdata | output | HALF_W | Half-word write data |
| cmd_done | input | 1 | Command completed |
| cmd_err | input | 1 | Command failed, valid with cmd_done |
| cmd_rdata | input | HALF_W | Read half, valid with cmd_done |
| last_page | output | PAGE_W | Last acknowledged page value |

## Verification
The response pulse of one sequence and the acceptance of the next request fall in the same cycle. The bench drives each new request on the very edge where it sees `rsp_valid`, and then checks that the response data and flag belong to the finished sequence while the new transaction log matches only the new request. A second collision, a host request held high while a modify is still running, is provoked mid-sequence, and is judged by the exact length and content of the command log, which must show no extra transactions.

// File: rtl/prb_pkg.sv
package prb_pkg;
   typedef enum logic [1:0] {
      OP_READ   = 2'b00,
      OP_WRITE  = 2'b01,
      OP_MODIFY = 2'b10,
      OP_RSVD   = 2'b11
   } prb_op_e;

   localparam int PRB_PHY_W = 5;
   localparam int PRB_REG_W = 5;
   localparam logic [PRB_PHY_W-1:0] PRB_PAGE_PHY = 5'h18;
   localparam logic [PRB_REG_W-1:0] PRB_PAGE_REG = 5'h00;
endpackage

// File: rtl/prb_addr_map.sv
module prb_addr_map #(
   parameter int ADDR_W = 32,
   parameter int PAGE_W = 16
) (
   input  logic [ADDR_W-1:0]              half_addr,
   output logic [PAGE_W-1:0]              page,
   output logic [prb_pkg::PRB_PHY_W-1:0]  phy,
   output logic [prb_pkg::PRB_REG_W-1:0]  regn
);
   localparam int PAGE_LSB = 9;
   localparam int SRC_W    = ADDR_W - PAGE_LSB;

   generate
      if (ADDR_W < 10) begin : g_bad_addr
         $error("prb_addr_map: ADDR_W must be at least 10");
      end
      if (SRC_W >= PAGE_W) begin : g_page_slice
         assign page = half_addr[PAGE_LSB +: PAGE_W];
      end else begin : g_page_pad
         always_comb begin
            page = '0;
            page[SRC_W-1:0] = half_addr[ADDR_W-1:PAGE_LSB];
         end
      end
   endgenerate

   // R1 mapping: PHY window 0x10..0x17, register from bits 5:1
   assign phy  = {2'b10, half_addr[8:6]};
   assign regn = half_addr[5:1];
endmodule

// File: rtl/prb_merge.sv
module prb_merge #(
   parameter int WORD_W = 32
) (
   input  prb_pkg::prb_op_e    op,
   input  logic [WORD_W-1:0]   wdata,
   input  logic [WORD_W-1:0]   mask,
   input  logic [WORD_W-1:0]   old_word,
   output logic [WORD_W-1:0]   wr_word
);
   always_comb begin
      if (op == prb_pkg::OP_MODIFY) wr_word = (old_word & ~mask) | wdata;
      else                          wr_word = wdata;
   end
endmodule

// File: rtl/prb_seq.sv
module prb_seq #(
   parameter int ADDR_W = 32,
   parameter int HALF_W = 16,
   parameter int PAGE_W = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   input  logic [1:0]            req_op,
   input  logic [ADDR_W-1:0]     req_addr,
   input  logic [2*HALF_W-1:0]   req_wdata,
   input  logic [2*HALF_W-1:0]   req_mask,
   input  logic                  cmd_done,
   input  logic                  cmd_err,
   input  logic [HALF_W-1:0]     cmd_rdata,
   input  logic [PAGE_W-1:0]     cur_page,
   output logic                  busy,
   output prb_pkg::prb_op_e      op,
   output logic [ADDR_W-1:0]     base_addr,
   output logic [2*HALF_W-1:0]   wdata,
   output logic [2*HALF_W-1:0]   mask,
   output logic [2*HALF_W-1:0]   old_word,
   output logic                  page_phase,
   output logic                  half_hi,
   output logic                  access_write,
   output logic                  rsp_valid,
   output logic                  rsp_err,
   output logic [2*HALF_W-1:0]   rsp_rdata,
   output logic [PAGE_W-1:0]     last_page
);
   import prb_pkg::*;

   localparam int WORD_W = 2 * HALF_W;
   localparam int STEP_W = 3;
   localparam logic [STEP_W-1:0] LAST_SHORT = 3'd3;
   localparam logic [STEP_W-1:0] LAST_LONG  = 3'd7;

   logic                busy_q;
   prb_op_e             op_q;
   logic [ADDR_W-1:0]   addr_q;
   logic [WORD_W-1:0]   wdata_q, mask_q;
   logic [STEP_W-1:0]   step_q;
   logic [HALF_W-1:0]   rd_lo_q, rd_hi_q;
   logic                rsp_valid_q, rsp_err_q;
   logic [WORD_W-1:0]   rsp_rdata_q;
   logic [PAGE_W-1:0]   last_page_q;

   logic [1:0]          half_idx;
   logic [STEP_W-1:0]   last_step;
   logic                accept, fire;
   logic [WORD_W-1:0]   final_word;

   assign half_idx     = step_q[2:1];
   assign page_phase   = ~step_q[0];
   assign half_hi      = half_idx[0];
   assign access_write = (op_q == OP_WRITE) || (op_q == OP_MODIFY && half_idx[1]);
   assign last_step    = (op_q == OP_MODIFY) ? LAST_LONG : LAST_SHORT;
   assign accept       = req_valid && !busy_q;
   assign fire         = busy_q && cmd_done;

   always_comb begin
      unique case (op_q)
         OP_WRITE:  final_word = '0;
         OP_MODIFY: final_word = {rd_hi_q, rd_lo_q};
         default:   final_word = {cmd_rdata, rd_lo_q};
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q      <= 1'b0;
         op_q        <= OP_READ;
         addr_q      <= '0;
         wdata_q     <= '0;
         mask_q      <= '0;
         step_q      <= '0;
         rd_lo_q     <= '0;
         rd_hi_q     <= '0;
         rsp_valid_q <= 1'b0;
         rsp_err_q   <= 1'b0;
         rsp_rdata_q <= '0;
         last_page_q <= '0;
      end else begin
         rsp_valid_q <= 1'b0;
         if (accept) begin
            busy_q  <= 1'b1;
            op_q    <= prb_op_e'(req_op);
            addr_q  <= {req_addr[ADDR_W-1:2], 2'b00};
            wdata_q <= req_wdata;
            mask_q  <= req_mask;
            step_q  <= '0;
         end else if (fire) begin
            if (cmd_err) begin
               busy_q      <= 1'b0;
               rsp_valid_q <= 1'b1;
               rsp_err_q   <= 1'b1;
               rsp_rdata_q <= '0;
            end else begin
               if (page_phase) last_page_q <= cur_page;
               if (!page_phase && !access_write) begin
                  if (half_hi) rd_hi_q <= cmd_rdata;
                  else         rd_lo_q <= cmd_rdata;
               end
               if (step_q == last_step) begin
                  busy_q      <= 1'b0;
                  rsp_valid_q <= 1'b1;
                  rsp_err_q   <= 1'b0;
                  rsp_rdata_q <= final_word;
               end else begin
                  step_q <= step_q + 1'b1;
               end
            end
         end
      end
   end

   assign busy      = busy_q;
   assign op        = op_q;
   assign base_addr = addr_q;
   assign wdata     = wdata_q;
   assign mask      = mask_q;
   assign old_word  = {rd_hi_q, rd_lo_q};
   assign rsp_valid = rsp_valid_q;
   assign rsp_err   = rsp_err_q;
   assign rsp_rdata = rsp_rdata_q;
   assign last_page = last_page_q;

   // R7
   rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid_q |=> !rsp_valid_q);

   // R7
   busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> rsp_valid_q);

   // R7
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !cmd_done) |=> (busy_q && $stable(addr_q) && $stable(op_q)));
endmodule

// File: rtl/paged_reg_bridge.sv
module paged_reg_bridge #(
   parameter int ADDR_W = 32,
   parameter int HALF_W = 16,
   parameter int PAGE_W = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   input  logic [1:0]            req_op,
   input  logic [ADDR_W-1:0]     req_addr,
   input  logic [2*HALF_W-1:0]   req_wdata,
   input  logic [2*HALF_W-1:0]   req_mask,
   output logic                  busy,
   output logic                  rsp_valid,
   output logic                  rsp_err,
   output logic [2*HALF_W-1:0]   rsp_rdata,
   output logic                  cmd_valid,
   output logic                  cmd_write,
   output logic [4:0]            cmd_phy,
   output logic [4:0]            cmd_reg,
   output logic [HALF_W-1:0]     cmd_wdata,
   input  logic                  cmd_done,
   input  logic                  cmd_err,
   input  logic [HALF_W-1:0]     cmd_rdata,
   output logic [PAGE_W-1:0]     last_page
);
   import prb_pkg::*;

   localparam int WORD_W = 2 * HALF_W;

   generate
      if (PAGE_W > HALF_W) begin : g_bad_page
         $error("paged_reg_bridge: PAGE_W must not exceed HALF_W");
      end
      if (HALF_W < 1) begin : g_bad_half
         $error("paged_reg_bridge: HALF_W must be positive");
      end
   endgenerate

   prb_op_e             op;
   logic [ADDR_W-1:0]   base_addr, half_addr;
   logic [WORD_W-1:0]   wdata, mask, old_word, wr_word;
   logic                page_phase, half_hi, access_write;
   logic [PAGE_W-1:0]   page;
   logic [PRB_PHY_W-1:0] map_phy;
   logic [PRB_REG_W-1:0] map_reg;
   logic [HALF_W-1:0]   page_ext;

   prb_seq #(.ADDR_W(ADDR_W), .HALF_W(HALF_W), .PAGE_W(PAGE_W)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_mask(req_mask),
      .cmd_done(cmd_done), .cmd_err(cmd_err), .cmd_rdata(cmd_rdata),
      .cur_page(page),
      .busy(busy), .op(op), .base_addr(base_addr),
      .wdata(wdata), .mask(mask), .old_word(old_word),
      .page_phase(page_phase), .half_hi(half_hi), .access_write(access_write),
      .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
      .last_page(last_page)
   );

   assign half_addr = {base_addr[ADDR_W-1:2], half_hi, 1'b0};

   prb_addr_map #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_map (
      .half_addr(half_addr), .page(page), .phy(map_phy), .regn(map_reg)
   );

   prb_merge #(.WORD_W(WORD_W)) u_merge (
      .op(op), .wdata(wdata), .mask(mask), .old_word(old_word), .wr_word(wr_word)
   );

   always_comb begin
      page_ext = '0;
      page_ext[PAGE_W-1:0] = page;
   end

   assign cmd_valid = busy;

   always_comb begin
      if (page_phase) begin
         cmd_write = 1'b1;
         cmd_phy   = PRB_PAGE_PHY;
         cmd_reg   = PRB_PAGE_REG;
         cmd_wdata = page_ext;
      end else begin
         cmd_write = access_write;
         cmd_phy   = map_phy;
         cmd_reg   = map_reg;
         cmd_wdata = half_hi ? wr_word[WORD_W-1:HALF_W] : wr_word[HALF_W-1:0];
      end
   end

   // R8
   cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_done) |=> (cmd_valid && $stable(cmd_phy) && $stable(cmd_reg)
                                    && $stable(cmd_write) && $stable(cmd_wdata)));

   // R1
   phy_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_phy != PRB_PAGE_PHY) |-> (cmd_phy[4:3] == 2'b10));

   // R2
   page_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_done && !cmd_err && cmd_phy != PRB_PAGE_PHY)
      |=> (!cmd_valid || cmd_phy == PRB_PAGE_PHY));

   // R9
   err_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_done && cmd_err) |=> (rsp_valid && rsp_err && !busy));
endmodule

// File: tb/paged_reg_bridge_test.sv
module paged_reg_bridge_test;
   localparam int ADDR_W = 32;
   localparam int HALF_W = 16;
   localparam int PAGE_W = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_op = 2'b00;
   logic [31:0] req_addr = '0, req_wdata = '0, req_mask = '0;
   logic        busy, rsp_valid, rsp_err, cmd_valid, cmd_write;
   logic [31:0] rsp_rdata;
   logic [4:0]  cmd_phy, cmd_reg;
   logic [15:0] cmd_wdata, last_page;
   logic        cmd_done = 1'b0, cmd_err = 1'b0;
   logic [15:0] cmd_rdata = '0;

   int checks = 0, failures = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   paged_reg_bridge #(.ADDR_W(ADDR_W), .HALF_W(HALF_W), .PAGE_W(PAGE_W)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
      .busy(busy), .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
      .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_phy(cmd_phy),
      .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata), .cmd_done(cmd_done),
      .cmd_err(cmd_err), .cmd_rdata(cmd_rdata), .last_page(last_page)
   );

   // downstream model: random latency, logs every transaction
   logic [4:0]  log_phy [0:15];
   logic [4:0]  log_reg [0:15];
   logic        log_wr  [0:15];
   logic [15:0] log_dat [0:15];
   int          log_n = 0;
   int          err_at = 99;
   logic [15:0] model_page = '0;
   bit          pending = 0;
   int          lat = 0;

   function automatic logic [15:0] rd_value(logic [15:0] pg, logic [4:0] p, logic [4:0] r);
      return {pg[5:0], p, r} ^ 16'h5A3C;
   endfunction

   always @(negedge clk) begin
      if (cmd_done) begin
         cmd_done = 1'b0;
         cmd_err  = 1'b0;
         pending  = 0;
      end else if (cmd_valid) begin
         if (!pending) begin
            pending = 1;
            lat = $urandom % 4;
         end
         if (lat == 0) begin
            if (log_n < 16) begin
               log_phy[log_n] = cmd_phy;
               log_reg[log_n] = cmd_reg;
               log_wr[log_n]  = cmd_write;
               log_dat[log_n] = cmd_wdata;
            end
            cmd_err = (log_n == err_at);
            if (cmd_write && cmd_phy == 5'h18 && cmd_reg == 5'h00) model_page = cmd_wdata;
            cmd_rdata = cmd_write ? 16'h0 : rd_value(model_page, cmd_phy, cmd_reg);
            log_n++;
            cmd_done = 1'b1;
         end else begin
            lat--;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // expected model, computed from the requirements
   logic [4:0]  exp_phy [0:7];
   logic [4:0]  exp_reg [0:7];
   logic        exp_wr  [0:7];
   logic [15:0] exp_dat [0:7];
   logic [15:0] exp_last_page = '0;

   function automatic logic [4:0]  map_phy(logic [31:0] h); return 5'h10 | 5'((h >> 6) & 7); endfunction
   function automatic logic [4:0]  map_reg(logic [31:0] h); return 5'((h >> 1) & 32'h1F); endfunction
   function automatic logic [15:0] map_page(logic [31:0] h); return 16'((h >> 9) & 32'hFFFF); endfunction

   task automatic run_op(input logic [1:0] op, input logic [31:0] addr, input logic [31:0] wd,
                         input logic [31:0] mk, input int err_idx, input bit intrude,
                         input string tag);
      logic [31:0] a, old, wword, exp_data;
      logic [15:0] pg;
      int nh, total, exp_n, cnt;
      bit has_err;
      a   = addr & ~32'h3;
      pg  = map_page(a);
      old = {rd_value(pg, map_phy(a + 2), map_reg(a + 2)), rd_value(pg, map_phy(a), map_reg(a))};
      wword = (op == 2'b01) ? wd : ((old & ~mk) | wd);
      nh    = (op == 2'b10) ? 4 : 2;
      total = 2 * nh;
      for (int h = 0; h < nh; h++) begin
         logic [31:0] ha;
         ha = a + 32'(2 * (h & 1));
         exp_phy[2*h] = 5'h18; exp_reg[2*h] = 5'h00; exp_wr[2*h] = 1'b1; exp_dat[2*h] = pg;
         exp_phy[2*h+1] = map_phy(ha);
         exp_reg[2*h+1] = map_reg(ha);
         exp_wr[2*h+1]  = (op == 2'b01) || (h >= 2);
         exp_dat[2*h+1] = (h & 1) ? wword[31:16] : wword[15:0];
      end
      has_err = (err_idx < total);
      exp_n   = has_err ? err_idx + 1 : total;
      if (!has_err || err_idx >= 1) exp_last_page = pg;
      exp_data = has_err ? 32'h0 : ((op == 2'b01) ? 32'h0 : old);

      log_n  = 0;
      err_at = err_idx;
      chk(busy == 1'b0, "R7", "idle before request", {31'b0, busy}, 32'h0);
      req_valid = 1'b1; req_op = op; req_addr = addr; req_wdata = wd; req_mask = mk;
      @(negedge clk);
      req_valid = 1'b0;
      chk(busy == 1'b1, "R7", "busy after accept", {31'b0, busy}, 32'h1);
      if (intrude) begin
         @(negedge clk);
         req_valid = 1'b1; req_op = 2'b01; req_addr = addr ^ 32'h0001_0040; req_wdata = ~wd;
         repeat (2) @(negedge clk);
         req_valid = 1'b0;
      end
      cnt = 0;
      while (!rsp_valid && cnt < 400) begin
         @(negedge clk);
         cnt++;
      end
      chk(rsp_valid == 1'b1, tag, "response seen", {31'b0, rsp_valid}, 32'h1);
      chk(busy == 1'b0, "R7", "busy low with response", {31'b0, busy}, 32'h0);
      chk(log_n == exp_n, has_err ? "R9" : tag, "transaction count", 32'(log_n), 32'(exp_n));
      for (int i = 0; i < exp_n && i < log_n; i++) begin
         bit ok;
         ok = (log_phy[i] == exp_phy[i]) && (log_reg[i] == exp_reg[i]) && (log_wr[i] == exp_wr[i])
              && (!exp_wr[i] || log_dat[i] == exp_dat[i]);
         chk(ok, (i % 2 == 0) ? "R2" : tag, $sformatf("txn %0d phy/reg/wr/data", i),
             {log_phy[i], log_reg[i], 5'b0, log_wr[i], log_dat[i]},
             {exp_phy[i], exp_reg[i], 5'b0, exp_wr[i], exp_dat[i]});
      end
      chk(rsp_err == has_err, has_err ? "R9" : tag, "response error flag", {31'b0, rsp_err}, {31'b0, has_err});
      chk(rsp_rdata == exp_data, has_err ? "R9" : tag, "response data", rsp_rdata, exp_data);
      chk(last_page == exp_last_page, "R10", "last page", {16'b0, last_page}, {16'b0, exp_last_page});
      err_at = 99;
   endtask

   initial begin
      void'($urandom(32'h00C0FFEE));
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(busy == 1'b0 && cmd_valid == 1'b0 && rsp_valid == 1'b0, "R11", "reset outputs",
          {29'b0, busy, cmd_valid, rsp_valid}, 32'h0);
      chk(last_page == 16'h0, "R11", "reset last_page", {16'b0, last_page}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      run_op(2'b00, 32'h0000_0000, 32'h0, 32'h0, 99, 0, "R4");
      run_op(2'b01, 32'h0000_01FC, 32'hA5A5_3C3C, 32'h0, 99, 0, "R3");
      run_op(2'b01, 32'h0000_01F8, 32'h1234_5678, 32'h0, 99, 0, "R2");   // same page again
      run_op(2'b00, 32'hFFFF_FFFC, 32'h0, 32'h0, 99, 0, "R1");
      run_op(2'b00, 32'h0012_3443, 32'h0, 32'h0, 99, 0, "R6");          // low bits set
      run_op(2'b01, 32'h0000_8A45, 32'hDEAD_BEEF, 32'h0, 99, 0, "R6");
      run_op(2'b10, 32'h0003_0A08, 32'h0000_F00F, 32'hFFFF_0FF0, 99, 0, "R5");
      run_op(2'b10, 32'h0007_7E44, 32'h8000_0001, 32'h00FF_00FF, 99, 1, "R7"); // request while busy
      run_op(2'b01, 32'h0000_4400, 32'h0, 32'h0, 0, 0, "R9");
      run_op(2'b00, 32'h0000_4404, 32'h0, 32'h0, 1, 0, "R9");
      run_op(2'b10, 32'h0000_4408, 32'h1, 32'h2, 5, 0, "R9");
      run_op(2'b10, 32'h0000_440C, 32'h1, 32'h2, 7, 0, "R9");
      run_op(2'b00, 32'h0000_0200, 32'h0, 32'h0, 99, 0, "R8");

      for (int k = 0; k < 60; k++) begin
         logic [1:0] op;
         int e;
         op = 2'($urandom % 3);
         e  = ($urandom % 5 == 0) ? int'($urandom % 8) : 99;
         run_op(op, $urandom, $urandom, $urandom, e, 0, op == 2'b00 ? "R4" : (op == 2'b01 ? "R3" : "R5"));
      end

      repeat (2) @(negedge clk);
      chk(busy == 1'b0 && cmd_valid == 1'b0, "R7", "idle at end", {30'b0, busy, cmd_valid}, 32'h0);
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      end
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      end
      $finish;
   end
endmodule